// File: doc/BRIEF.md
# Serial SAR converter host with sleep and wake sequencing

This block drives a three-wire link to an 8-bit successive-approximation converter. It controls an active-low chip select (`adc_cs_n`) and a serial clock (`adc_sclk`), and it reads the converter's serial output (`adc_sdata`). A conversion frame lasts sixteen serial clocks. The sixteen-bit word it collects starts with four zero bits, then carries the 8-bit result, then ends with four bits that the block ignores. The serial clock is derived from the system clock by a divider.

The converter has no mode pins, so its power mode is changed through the frame itself. A sleep frame raises chip select on purpose just after the fifth falling serial-clock edge. This sends the converter into power-down, and the bits gathered in that frame are discarded. A wake frame holds chip select low for all sixteen clocks, which powers the converter back up, and its data is discarded too. The block tracks which mode the converter is in and refuses conversions while the converter sleeps.

Commands are accepted when `cmd_valid` and `cmd_ready` are both high on a clock edge. The opcodes are: 0 convert, 1 sleep, 2 wake, 3 reserved. Results come back on `res_data` and `res_err`, with a one-cycle `res_valid` strobe.

Top module: `sar_link_host`

## Requirements
- R1: While reset is high and on its release, `adc_cs_n` and `adc_sclk` are 1, `res_valid` is 0, `powered_down` is 0 and `busy` is 1. `cmd_ready` first goes high exactly CS_GAP system clocks after reset is released.
- R2: The serial clock idles high whenever chip select is high. Inside a frame, the first falling edge comes DIV_HALF system clocks after chip select falls, and each later falling edge comes 2*DIV_HALF system clocks after the one before.
- R3: A convert command (opcode 0) accepted while the converter is powered runs a frame of exactly 16 falling edges. `adc_sdata` is sampled at each falling edge, first bit taken as bit 15. After chip select rises, `res_valid` pulses once and `res_data` equals bits [11:4] of the collected word.
- R4: `res_err` is 1 exactly when any of bits [15:12] of the collected conversion word is 1. Bits [3:0] affect neither `res_data` nor `res_err`.
- R5: A sleep command (opcode 1) accepted while powered raises chip select after exactly PD_EDGE (default 5) falling edges. It sets `powered_down` to 1, produces no `res_valid`, and leaves `res_data` unchanged.
- R6: A wake command (opcode 2) accepted while powered down runs a frame of exactly 16 falling edges. It clears `powered_down`, produces no `res_valid`, and leaves `res_data` unchanged.
- R7: A convert command accepted while powered down, or any opcode 3 command, starts no frame and pulses `cmd_rej` for one cycle in the cycle after acceptance.
- R8: A sleep command while already powered down, or a wake command while powered, is accepted without starting a frame, without `cmd_rej`, and without a change of `powered_down`.
- R9: Between the end of one frame and the start of the next, chip select stays high for at least CS_GAP system clocks.
- R10: `cmd_ready` is always the inverse of `busy`. `busy` is high for the whole time chip select is low and in the cycle after a frame-starting command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 0 convert, 1 sleep, 2 wake, 3 reserved |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_rej | output | 1 | One-cycle pulse: last accepted command was refused |
| busy | output | 1 | Frame or inter-frame gap in progress |
| powered_down | output | 1 | Converter is believed to be in power-down |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdata | input | 1 | Serial data from the converter |
| res_data | output | RES_W | Last valid conversion result |
| res_err | output | 1 | Leading-zero check failed on the last result |
| res_valid | output | 1 | One-cycle pulse: new result available |

## Verification
The bench builds the block with DIV_HALF=2 and CS_GAP=3. This keeps a conversion frame under eighty system clocks, so every one of the 256 result codes and all fifteen nonzero leading-nibble patterns can be driven through a behavioural converter model. The model counts falling edges and decides power-down and wake-up from the edge count at which chip select rises. That lets the bench confirm that sleep and wake frames really switch the converter's mode. The same short timing lets every falling-edge spacing and every chip-select gap be measured in cycles.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

  typedef enum logic [1:0] {
    OP_CONV  = 2'd0,
    OP_SLEEP = 2'd1,
    OP_WAKE  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FRAME = 2'd2
  } st_e;

  typedef enum logic [1:0] {
    FK_CONV  = 2'd0,
    FK_SLEEP = 2'd1,
    FK_WAKE  = 2'd2
  } fk_e;

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_stb,
  output logic rise_stb
);

  logic tick;

  generate
    if (DIV_HALF == 1) begin : g_fast
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign tick = (cnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk <= 1'b1;
    end else if (tick) begin
      sclk <= ~sclk;
    end
  end

  // strobes mark the system edge on which the serial clock changes
  assign fall_stb = run & tick & sclk;
  assign rise_stb = run & tick & ~sclk;

endmodule

// File: rtl/sar_rx_shift.sv
module sar_rx_shift #(
  parameter int FRAME_LEN  = 16,
  parameter int LEAD_ZEROS = 4,
  parameter int RES_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             sdata,
  output logic [RES_W-1:0] res,
  output logic             lead_err
);

  localparam int RES_TOP  = FRAME_LEN - LEAD_ZEROS - 1;
  localparam int LEAD_TOP = FRAME_LEN - 1;

  logic [FRAME_LEN-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (shift_en) begin
      sh <= {sh[FRAME_LEN-2:0], sdata};
    end
  end

  assign res      = sh[RES_TOP -: RES_W];
  assign lead_err = |sh[LEAD_TOP -: LEAD_ZEROS];

endmodule

// File: rtl/sar_frame_fsm.sv
module sar_frame_fsm
  import sar_link_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int PD_EDGE   = 5,
  parameter int CS_GAP    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       fall_stb,
  input  logic       rise_stb,
  output logic       cmd_ready,
  output logic       busy,
  output logic       cmd_rej,
  output logic       powered_down,
  output logic       cs_n,
  output logic       run,
  output logic       conv_done
);

  localparam int EW = $clog2(FRAME_LEN + 1);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [EW-1:0] LEN_E   = EW'(FRAME_LEN);
  localparam logic [EW-1:0] SLEEP_E = EW'(PD_EDGE);
  localparam logic [GW-1:0] GAP_END = GW'(CS_GAP - 1);

  st_e           st;
  fk_e           kind;
  logic [EW-1:0] edges;
  logic [GW-1:0] gap_cnt;
  logic [EW-1:0] target;

  logic go;
  logic bad;
  fk_e  go_kind;
  op_e  op;

  assign op = op_e'(cmd_op);

  // decode a command offered in idle into start / refuse / no-op
  always_comb begin
    go      = 1'b0;
    bad     = 1'b0;
    go_kind = FK_CONV;
    if (st == ST_IDLE && cmd_valid) begin
      case (op)
        OP_CONV: begin
          if (powered_down) bad = 1'b1;
          else go = 1'b1;
          go_kind = FK_CONV;
        end
        OP_SLEEP: begin
          go      = !powered_down;
          go_kind = FK_SLEEP;
        end
        OP_WAKE: begin
          go      = powered_down;
          go_kind = FK_WAKE;
        end
        default: bad = 1'b1;
      endcase
    end
  end

  assign target = (kind == FK_SLEEP) ? SLEEP_E : LEN_E;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_GAP;
      kind         <= FK_CONV;
      edges        <= '0;
      gap_cnt      <= '0;
      cs_n         <= 1'b1;
      run          <= 1'b0;
      powered_down <= 1'b0;
      cmd_rej      <= 1'b0;
      conv_done    <= 1'b0;
    end else begin
      cmd_rej   <= bad;
      conv_done <= 1'b0;
      case (st)
        ST_GAP: begin
          if (gap_cnt == GAP_END) begin
            st      <= ST_IDLE;
            gap_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (go) begin
            st    <= ST_FRAME;
            kind  <= go_kind;
            edges <= '0;
            cs_n  <= 1'b0;
            run   <= 1'b1;
          end
        end
        ST_FRAME: begin
          if (fall_stb) begin
            edges <= edges + 1'b1;
          end
          if (rise_stb && edges == target) begin
            cs_n    <= 1'b1;
            run     <= 1'b0;
            st      <= ST_GAP;
            gap_cnt <= '0;
            case (kind)
              FK_CONV:  conv_done    <= 1'b1;
              FK_SLEEP: powered_down <= 1'b1;
              default:  powered_down <= 1'b0;
            endcase
          end
        end
        default: st <= ST_GAP;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);

endmodule

// File: rtl/sar_link_host.sv
module sar_link_host #(
  parameter int DIV_HALF   = 4,
  parameter int CS_GAP     = 4,
  parameter int FRAME_LEN  = 16,
  parameter int LEAD_ZEROS = 4,
  parameter int RES_W      = 8,
  parameter int PD_EDGE    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  output logic             cmd_rej,
  output logic             busy,
  output logic             powered_down,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_sdata,
  output logic [RES_W-1:0] res_data,
  output logic             res_err,
  output logic             res_valid
);

  logic             run;
  logic             fall_stb;
  logic             rise_stb;
  logic             conv_done;
  logic [RES_W-1:0] rx_res;
  logic             rx_err;

  sar_sclk_gen #(
    .DIV_HALF(DIV_HALF)
  ) u_sclk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sclk     (adc_sclk),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
  );

  sar_rx_shift #(
    .FRAME_LEN (FRAME_LEN),
    .LEAD_ZEROS(LEAD_ZEROS),
    .RES_W     (RES_W)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .shift_en (fall_stb),
    .sdata    (adc_sdata),
    .res      (rx_res),
    .lead_err (rx_err)
  );

  sar_frame_fsm #(
    .FRAME_LEN(FRAME_LEN),
    .PD_EDGE  (PD_EDGE),
    .CS_GAP   (CS_GAP)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .fall_stb     (fall_stb),
    .rise_stb     (rise_stb),
    .cmd_ready    (cmd_ready),
    .busy         (busy),
    .cmd_rej      (cmd_rej),
    .powered_down (powered_down),
    .cs_n         (adc_cs_n),
    .run          (run),
    .conv_done    (conv_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_err   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= conv_done;
      if (conv_done) begin
        res_data <= rx_res;
        res_err  <= rx_err;
      end
    end
  end

endmodule

// File: rtl/sar_link_host_chk.sv
module sar_link_host_chk #(
  parameter int FRAME_LEN = 16,
  parameter int PD_EDGE   = 5,
  parameter int CS_GAP    = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       cmd_ready,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_rej,
  input logic       powered_down,
  input logic       res_valid
);

  localparam int EW = $clog2(FRAME_LEN + 2);
  localparam int HW = $clog2(CS_GAP + 1) + 1;

  logic          cs_q;
  logic          sclk_q;
  logic [EW-1:0] fall_cnt;
  logic [EW-1:0] last_len;
  logic [HW-1:0] hi_cnt;
  logic          cs_up;
  logic          cs_dn;

  assign cs_up = cs_n && !cs_q;
  assign cs_dn = !cs_n && cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      fall_cnt <= '0;
      last_len <= '0;
      hi_cnt   <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_dn) fall_cnt <= '0;
      else if (sclk_q && !sclk) fall_cnt <= fall_cnt + 1'b1;
      if (cs_up) last_len <= fall_cnt;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt < HW'(CS_GAP)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk); // R2

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    cs_up |-> (fall_cnt == EW'(PD_EDGE) || fall_cnt == EW'(FRAME_LEN))); // R3

  AST_RESULT_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (last_len == EW'(FRAME_LEN))); // R3

  AST_SLEEP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cs_up && fall_cnt == EW'(PD_EDGE)) |-> powered_down); // R5

  AST_FULL_FRAME_POWERED: assert property (@(posedge clk) disable iff (rst)
    (cs_up && fall_cnt == EW'(FRAME_LEN)) |-> !powered_down); // R6

  AST_CONV_WHILE_DOWN_REJ: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd0 && powered_down) |=> (cmd_rej && cs_n)); // R7

  AST_RSVD_REJ: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> (cmd_rej && cs_n)); // R7

  AST_MIN_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    cs_dn |-> (hi_cnt >= HW'(CS_GAP))); // R9

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (busy && !cmd_ready)); // R10

endmodule

bind sar_link_host sar_link_host_chk #(
  .FRAME_LEN(FRAME_LEN),
  .PD_EDGE  (PD_EDGE),
  .CS_GAP   (CS_GAP)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (adc_cs_n),
  .sclk         (adc_sclk),
  .busy         (busy),
  .cmd_ready    (cmd_ready),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_rej      (cmd_rej),
  .powered_down (powered_down),
  .res_valid    (res_valid)
);

// File: tb/sar_link_host_tb_top.sv
`timescale 1ns/1ps
module sar_link_host_tb_top;

  localparam int DIV_HALF = 2;
  localparam int CS_GAP   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_ready, cmd_rej, busy, powered_down;
  logic       adc_cs_n, adc_sclk;
  logic       adc_sdata = 1'b0;
  logic [7:0] res_data;
  logic       res_err, res_valid;

  always #5 clk = ~clk;

  sar_link_host #(
    .DIV_HALF(DIV_HALF),
    .CS_GAP  (CS_GAP)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_ready    (cmd_ready),
    .cmd_rej      (cmd_rej),
    .busy         (busy),
    .powered_down (powered_down),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .adc_sdata    (adc_sdata),
    .res_data     (res_data),
    .res_err      (res_err),
    .res_valid    (res_valid)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // converter model and link monitor state
  int cyc = 0, nfall = 0, last_fall = 0, cs_fall = 0, hi_run = 0;
  int frames = 0, last_len = 0, nvalid = 0, nrej = 0;
  int per_bad = 0, gap_bad = 0, rdy_bad = 0;
  bit model_pd = 0;
  logic        cs_prev = 1'b1, sclk_prev = 1'b1;
  logic [15:0] word = '0;
  logic [3:0]  drv_lead = '0, drv_trail = '0;
  logic [7:0]  drv_val = '0;
  logic [7:0]  cap_data = '0;
  logic        cap_err = 1'b0;
  logic        rej_seen = 1'b0, busy_seen = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int exp_c;
      cyc++;
      if (cmd_ready == busy) rdy_bad++;
      if (res_valid) begin nvalid++; cap_data = res_data; cap_err = res_err; end
      if (cmd_rej) nrej++;
      if (cs_prev && !adc_cs_n) begin
        if (hi_run < CS_GAP) gap_bad++;
        nfall   = 0;
        cs_fall = cyc;
        word    = model_pd ? 16'hFFFF : {drv_lead, drv_val, drv_trail};
        adc_sdata = word[15];
      end
      if (!adc_cs_n && sclk_prev && !adc_sclk) begin
        nfall++;
        exp_c = (nfall == 1) ? cs_fall + DIV_HALF : last_fall + 2 * DIV_HALF;
        if (cyc != exp_c) per_bad++;
        last_fall = cyc;
        adc_sdata = (nfall < 16) ? word[15 - nfall] : 1'b0;
      end
      if (adc_cs_n && !adc_sclk) per_bad++;
      if (!cs_prev && adc_cs_n) begin
        frames++;
        last_len = nfall;
        if (nfall >= 2 && nfall < 10) model_pd = 1;
        else if (nfall >= 10) model_pd = 0;
      end
      if (adc_cs_n) hi_run++; else hi_run = 0;
      cs_prev   = adc_cs_n;
      sclk_prev = adc_sclk;
    end
  end

  task automatic run_cmd(input logic [1:0] op);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    rej_seen  = cmd_rej;
    busy_seen = busy;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int f0, v0, r0, n;
    logic [7:0] keep;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n in reset", adc_cs_n, 1);
    chk("R1 sclk in reset", adc_sclk, 1);
    chk("R1 res_valid in reset", res_valid, 0);
    chk("R1 powered_down in reset", powered_down, 0);
    chk("R1 busy in reset", busy, 1);
    rst = 1'b0;
    n = 0;
    while (!cmd_ready) begin @(negedge clk); n++; end
    chk("R1 ready delay", n, CS_GAP);

    // R3 exhaustive sweep of result codes, R4 trailing bits ignored
    for (int v = 0; v < 256; v++) begin
      drv_lead  = 4'h0;
      drv_val   = 8'(v);
      drv_trail = 4'(v) ^ 4'h9;
      v0 = nvalid;
      run_cmd(2'd0);
      chk("R3 result", cap_data, v);
      chk("R3 valid pulses", nvalid - v0, 1);
      chk("R3 frame edges", last_len, 16);
      chk("R4 no error", cap_err, 0);
      chk("R10 busy after accept", busy_seen, 1);
    end

    // R4 every nonzero leading nibble
    for (int l = 1; l < 16; l++) begin
      drv_lead  = 4'(l);
      drv_val   = 8'h3C;
      drv_trail = 4'hF;
      run_cmd(2'd0);
      chk("R4 lead error", cap_err, 1);
      chk("R4 data with error", cap_data, 8'h3C);
    end
    drv_lead = 4'h0;

    // R5 sleep frame
    keep = res_data;
    f0 = frames; v0 = nvalid;
    run_cmd(2'd1);
    chk("R5 sleep edges", last_len, 5);
    chk("R5 model asleep", model_pd, 1);
    chk("R5 powered_down", powered_down, 1);
    chk("R5 no result", nvalid - v0, 0);
    chk("R5 data kept", res_data, keep);

    // R7 convert while asleep
    f0 = frames; v0 = nvalid;
    run_cmd(2'd0);
    chk("R7 reject pulse", rej_seen, 1);
    chk("R7 no frame", frames - f0, 0);
    chk("R7 no result", nvalid - v0, 0);
    chk("R7 data kept", res_data, keep);

    // R8 sleep while asleep
    f0 = frames; r0 = nrej;
    run_cmd(2'd1);
    chk("R8 sleep no frame", frames - f0, 0);
    chk("R8 sleep no reject", nrej - r0, 0);
    chk("R8 still asleep", powered_down, 1);

    // R6 wake frame
    f0 = frames; v0 = nvalid;
    run_cmd(2'd2);
    chk("R6 wake edges", last_len, 16);
    chk("R6 model awake", model_pd, 0);
    chk("R6 powered_down clear", powered_down, 0);
    chk("R6 no result", nvalid - v0, 0);
    chk("R6 data kept", res_data, keep);

    drv_val = 8'hA5; drv_trail = 4'h6;
    run_cmd(2'd0);
    chk("R3 result after wake", cap_data, 8'hA5);

    // R8 wake while awake
    f0 = frames; r0 = nrej;
    run_cmd(2'd2);
    chk("R8 wake no frame", frames - f0, 0);
    chk("R8 wake no reject", nrej - r0, 0);
    chk("R8 still awake", powered_down, 0);

    // R7 reserved opcode
    f0 = frames;
    run_cmd(2'd3);
    chk("R7 reserved reject", rej_seen, 1);
    chk("R7 reserved no frame", frames - f0, 0);

    // second sleep/wake round trip
    run_cmd(2'd1);
    chk("R5 second sleep", model_pd, 1);
    run_cmd(2'd2);
    chk("R6 second wake", model_pd, 0);
    drv_val = 8'h5A;
    run_cmd(2'd0);
    chk("R3 result after second wake", cap_data, 8'h5A);

    chk("R2 serial clock timing", per_bad, 0);
    chk("R9 chip-select gap", gap_bad, 0);
    chk("R10 ready is not busy", rdy_bad, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule